// File: doc/BRIEF.md
# Cascadable Auto-Reload Timer Unit

This block is a small timer subsystem for a microcontroller. It holds a clock divider fed by the instruction-clock enable and two 8-bit down counters. Each counter keeps a reload value. The divider passes on one enable pulse out of every 4 or every 16 instruction enables. Timer A counts either divider pulses or rising edges seen on an external interrupt pin. Timer B counts one of four sources: Timer A underflows, divider pulses, rising edges on an external counter pin, or every system clock cycle.

A loaded value n gives a divide of n+1. When a running counter reaches zero and receives one more count, it underflows. It then reloads, raises its own sticky interrupt flag and keeps counting. A square-wave output toggles on each underflow of whichever timer is selected. Software works the block through a small synchronous register port. Through that port it sets the control fields and writes timer values. It clears flags either by writing ones or by a test-and-clear read.

Top module: `tmr_cascade_unit`

Register map (3-bit address). Reads are combinational.
- 0: control.
  - bit0 runs Timer A and bit1 runs Timer B.
  - bit2 sets the divide ratio: 0 gives 4, 1 gives 16.
  - bit3 sets the Timer A source: 0 is the divider, 1 is the interrupt pin.
  - bits5:4 set the Timer B source: 0 is Timer A underflow, 1 is the divider, 2 is the counter pin, 3 is the system clock.
  - bit6 selects which timer drives the output: 0 is Timer A, 1 is Timer B.
- 1 and 2: Timer A and Timer B. A write sets the timer value. A read returns the current count.
- 3: flag register. Writing 1 to bit0 or bit1 clears the Timer A or Timer B flag. A read returns {Timer B flag, Timer A flag} in bits 1:0.
- 4 and 5: test-and-clear for Timer A and Timer B. A read returns the flag in bit0, and a read strobe on this address clears that flag.

## Requirements
- R1: After reset the control register, both counts and both reload values are 0, both flags are 0 and `cnt_out` is 0.
- R2: The divider emits one pulse for every 4 instruction enables when control bit2 is 0, and for every 16 when it is 1. Its pulses occur only in cycles where `instr_en` is high.
- R3: A write to a stopped timer loads its count and its reload value together. A write to a running timer changes only the reload value, and the visible count continues undisturbed.
- R4: A running timer whose count is n counts down by one on each count pulse. On the pulse that finds the count at 0 it underflows and loads its reload value, so the underflow period is n+1 pulses for n from 0 to 255.
- R5: A timer's flag is set in the cycle after its underflow. It stays set until software writes 1 to its bit in register 3. A write of 1 to the other bit leaves it set, and a set in the same cycle as a clear wins.
- R6: A read strobe at address 4 or 5 returns the Timer A or Timer B flag in bit0 and clears that flag. The other timer's flag is not affected.
- R7: Timer A counts divider pulses when control bit3 is 0. When bit3 is 1 it counts rising edges of `int_pin`, each seen once after a two-stage synchronizer.
- R8: Timer B counts the source chosen by control bits5:4: 0 is Timer A underflows, 1 is divider pulses, 2 is synchronized rising edges of `cnt_pin`, 3 is every clock.
- R9: `cnt_out` toggles in the cycle after each underflow of the timer selected by control bit6 (0 is Timer A, 1 is Timer B), and holds otherwise. Its period is twice the underflow period.
- R10: A stopped timer keeps its count whatever count pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_en | input | 1 | Instruction-clock enable, the divider's input |
| int_pin | input | 1 | External interrupt-pin count input, asynchronous |
| cnt_pin | input | 1 | External counter-pin count input, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe, used by the test-and-clear addresses |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| t1_irq | output | 1 | Timer A interrupt request flag |
| t2_irq | output | 1 | Timer B interrupt request flag |
| cnt_out | output | 1 | Square-wave output toggled on the selected timer's underflows |

## Verification
The assertions take for granted that `reg_addr`, `reg_we` and `reg_re` are driven to known values in every cycle after reset. They also assume that the external pins are plain levels that settle before a clock edge. The stimulus changes every input only on the falling clock edge. It holds each pin level for at least two cycles, so the synchronizer sees each rising edge exactly once. The stimulus stops a timer before reprogramming its value whenever the count must be defined. It sets the divide ratio and sources before starting a period measurement, and it discards the first output toggle after each change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned TMR_W  = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_TA    = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TB    = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_CLR   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_SKIPA = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_SKIPB = 3'd5;

    typedef enum logic [1:0] {
        TB_SRC_A_UF   = 2'd0,
        TB_SRC_DIV    = 2'd1,
        TB_SRC_PIN    = 2'd2,
        TB_SRC_SYSCLK = 2'd3
    } tb_src_e;

    typedef struct packed {
        logic    out_sel;
        tb_src_e tb_src;
        logic    ta_src;
        logic    div_hi;
        logic    tb_run;
        logic    ta_run;
    } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned DIV_LO = 4,
    parameter int unsigned DIV_HI = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_en,
    input  logic sel_hi,
    output logic pulse
);
    localparam int unsigned CW = $clog2(DIV_HI);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = sel_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
        pulse = 1'b0;
        if (step_en) begin
            if (st_q.cnt >= limit) begin
                pulse      = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } es_state_t;

    es_state_t st_d, st_q;

    always_comb begin
        st_d.sh = {st_q.sh[STAGES-1:0], pin};
        rise    = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         uf,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
    } dc_state_t;

    dc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf   = run && tick && (st_q.cnt == '0);
        if (wr_en) begin
            st_d.rel = wr_data;
            if (!run) st_d.cnt = wr_data;
        end
        if (run && tick) begin
            st_d.cnt = uf ? st_d.rel : st_q.cnt - 1'b1;
        end
        count = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_cascade_unit.sv
module tmr_cascade_unit
    import tmr_pkg::*;
#(
    parameter int unsigned DIV_LO      = 4,
    parameter int unsigned DIV_HI      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_en,
    input  logic              int_pin,
    input  logic              cnt_pin,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [TMR_W-1:0]  reg_wdata,
    output logic [TMR_W-1:0]  reg_rdata,
    output logic              t1_irq,
    output logic              t2_irq,
    output logic              cnt_out
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t ctrl;
        logic  fa;
        logic  fb;
        logic  out;
    } top_state_t;

    top_state_t st_d, st_q;

    logic             ps_pulse;
    logic             int_rise, cnt_rise;
    logic             t1_tick, t2_tick;
    logic             t1_uf, t2_uf, sel_uf;
    logic             t1_run, t2_run;
    logic             wr_ta, wr_tb;
    logic [TMR_W-1:0] t1_count, t2_count;

    assign t1_run = st_q.ctrl.ta_run;
    assign t2_run = st_q.ctrl.tb_run;
    assign wr_ta  = reg_we && (reg_addr == ADDR_TA);
    assign wr_tb  = reg_we && (reg_addr == ADDR_TB);

    tmr_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_ps (
        .clk(clk), .rst_n(rst_n), .step_en(instr_en),
        .sel_hi(st_q.ctrl.div_hi), .pulse(ps_pulse)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_int (
        .clk(clk), .rst_n(rst_n), .pin(int_pin), .rise(int_rise)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_cnt (
        .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .rise(cnt_rise)
    );

    always_comb begin
        t1_tick = st_q.ctrl.ta_src ? int_rise : ps_pulse;
        unique case (st_q.ctrl.tb_src)
            TB_SRC_A_UF:   t2_tick = t1_uf;
            TB_SRC_DIV:    t2_tick = ps_pulse;
            TB_SRC_PIN:    t2_tick = cnt_rise;
            default:       t2_tick = 1'b1;
        endcase
    end

    tmr_down_counter #(.W(TMR_W)) u_ta (
        .clk(clk), .rst_n(rst_n), .run(t1_run), .tick(t1_tick),
        .wr_en(wr_ta), .wr_data(reg_wdata), .uf(t1_uf), .count(t1_count)
    );

    tmr_down_counter #(.W(TMR_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(t2_run), .tick(t2_tick),
        .wr_en(wr_tb), .wr_data(reg_wdata), .uf(t2_uf), .count(t2_count)
    );

    always_comb begin
        st_d   = st_q;
        sel_uf = st_q.ctrl.out_sel ? t2_uf : t1_uf;

        if (reg_we && reg_addr == ADDR_CTRL) st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);

        if (reg_we && reg_addr == ADDR_CLR) begin
            if (reg_wdata[0]) st_d.fa = 1'b0;
            if (reg_wdata[1]) st_d.fb = 1'b0;
        end
        if (reg_re && reg_addr == ADDR_SKIPA) st_d.fa = 1'b0;
        if (reg_re && reg_addr == ADDR_SKIPB) st_d.fb = 1'b0;
        if (t1_uf) st_d.fa = 1'b1;
        if (t2_uf) st_d.fb = 1'b1;

        if (sel_uf) st_d.out = ~st_q.out;

        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = TMR_W'(st_q.ctrl);
            ADDR_TA:    reg_rdata = t1_count;
            ADDR_TB:    reg_rdata = t2_count;
            ADDR_CLR:   reg_rdata = TMR_W'({st_q.fb, st_q.fa});
            ADDR_SKIPA: reg_rdata = TMR_W'(st_q.fa);
            ADDR_SKIPB: reg_rdata = TMR_W'(st_q.fb);
            default:    reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign t1_irq  = st_q.fa;
    assign t2_irq  = st_q.fb;
    assign cnt_out = st_q.out;
endmodule

// File: rtl/tmr_cascade_chk.sv
module tmr_cascade_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              instr_en,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [TMR_W-1:0]  reg_wdata,
    input logic              t1_irq,
    input logic              t2_irq,
    input logic              cnt_out,
    input logic              ps_pulse,
    input logic              t1_uf,
    input logic              t2_uf,
    input logic              sel_uf,
    input logic              t1_tick,
    input logic              t1_run,
    input logic [TMR_W-1:0]  t1_count
);
    logic clr_a, clr_b, skip_a, wr_a;
    assign clr_a  = reg_we && reg_addr == ADDR_CLR && reg_wdata[0];
    assign clr_b  = reg_we && reg_addr == ADDR_CLR && reg_wdata[1];
    assign skip_a = reg_re && reg_addr == ADDR_SKIPA;
    assign wr_a   = reg_we && reg_addr == ADDR_TA;

    assert_div_on_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ps_pulse |-> instr_en);

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_run && t1_tick && t1_count != '0) |=> t1_count == TMR_W'($past(t1_count) - 1'b1));

    assert_flag_a_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        t1_uf |=> t1_irq);

    assert_flag_b_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        t2_uf |=> t2_irq);

    assert_flag_a_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_irq && !clr_a && !skip_a) |=> t1_irq);

    assert_flag_b_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_b && !t2_uf) |=> !t2_irq);

    assert_skip_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_a && !t1_uf) |=> !t1_irq);

    assert_out_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_uf |=> cnt_out != $past(cnt_out));

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_uf |=> $stable(cnt_out));

    assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!t1_run && !wr_a) |=> $stable(t1_count));
endmodule

bind tmr_cascade_unit tmr_cascade_chk i_chk (
    .clk(clk), .rst_n(rst_n), .instr_en(instr_en), .reg_we(reg_we),
    .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .t1_irq(t1_irq), .t2_irq(t2_irq), .cnt_out(cnt_out),
    .ps_pulse(ps_pulse), .t1_uf(t1_uf), .t2_uf(t2_uf), .sel_uf(sel_uf),
    .t1_tick(t1_tick), .t1_run(t1_run), .t1_count(t1_count)
);

// File: tb/test_tmr_cascade_unit.sv
module test_tmr_cascade_unit;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_en = 1'b1;
    logic       int_pin = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       t1_irq, t2_irq, cnt_out;

    int total = 0;
    int bad = 0;
    bit half_rate = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_cascade_unit i_tmr_cascade_unit (
        .clk(clk), .rst_n(rst_n), .instr_en(instr_en), .int_pin(int_pin),
        .cnt_pin(cnt_pin), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .t1_irq(t1_irq),
        .t2_irq(t2_irq), .cnt_out(cnt_out)
    );

    // vector: timer A value, timer B value, B source, A source, divider high,
    // output select, expected cycles between output toggles
    typedef struct packed {
        logic [7:0]  na;
        logic [7:0]  nb;
        logic [1:0]  bsrc;
        logic        asrc;
        logic        dhi;
        logic        osel;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'd0, 8'd3,   2'd3, 1'b0, 1'b0, 1'b1, 16'd4},   // R8 sysclk, R4
        '{8'd0, 8'd0,   2'd3, 1'b0, 1'b0, 1'b1, 16'd1},   // R4 n=0
        '{8'd0, 8'd255, 2'd3, 1'b0, 1'b0, 1'b1, 16'd256}, // R4 n=255
        '{8'd0, 8'd2,   2'd1, 1'b0, 1'b0, 1'b1, 16'd12},  // R2 /4, R8 divider
        '{8'd0, 8'd1,   2'd1, 1'b0, 1'b1, 1'b1, 16'd32},  // R2 /16
        '{8'd2, 8'd1,   2'd0, 1'b0, 1'b0, 1'b1, 16'd24},  // R8 cascade
        '{8'd4, 8'd0,   2'd3, 1'b0, 1'b0, 1'b0, 16'd20},  // R7 divider, R9 sel A
        '{8'd0, 8'd0,   2'd3, 1'b0, 1'b1, 1'b0, 16'd16}   // R9 sel A, R2
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic skip_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_toggle(output int k);
        logic prev;
        prev = cnt_out;
        k = 0;
        while (cnt_out == prev && k < 5000) begin
            @(negedge clk);
            if (half_rate) instr_en = ~instr_en;
            k++;
        end
    endtask

    task automatic pulse_pin(input bit which);
        @(negedge clk);
        if (which) cnt_pin = 1'b1; else int_pin = 1'b1;
        repeat (2) @(negedge clk);
        cnt_pin = 1'b0; int_pin = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, d); check(d == 8'd0, "R1 ctrl", d, 0);
        rd(3'd1, d); check(d == 8'd0, "R1 count A", d, 0);
        rd(3'd2, d); check(d == 8'd0, "R1 count B", d, 0);
        check(!t1_irq && !t2_irq && !cnt_out, "R1 flags/out",
              {t1_irq, t2_irq, cnt_out}, 0);

        // table of period vectors
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 8'd0);
            wr(3'd1, VEC[i].na);
            wr(3'd2, VEC[i].nb);
            wr(3'd0, {1'b0, VEC[i].osel, VEC[i].bsrc, VEC[i].asrc, VEC[i].dhi, 2'b11});
            wait_toggle(k);
            wait_toggle(k);
            check(k == int'(VEC[i].exp), "R4/R2/R8/R9 period", k, int'(VEC[i].exp));
        end

        // R2 divider counts instruction enables, not clocks
        wr(3'd0, 8'd0);
        wr(3'd2, 8'd0);
        wr(3'd0, {1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'b10});
        half_rate = 1'b1;
        wait_toggle(k);
        wait_toggle(k);
        half_rate = 1'b0;
        instr_en = 1'b1;
        check(k == 8, "R2 half-rate enable", k, 8);

        // R3 stopped write loads count
        wr(3'd0, 8'd0);
        wr(3'd3, 8'h03);
        wr(3'd1, 8'h10);
        rd(3'd1, d); check(d == 8'h10, "R3 stopped load", d, 8'h10);
        wr(3'd0, {1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 2'b01});
        wr(3'd1, 8'h20);
        rd(3'd1, d); check(d == 8'h10, "R3 running write keeps count", d, 8'h10);

        // R7 interrupt-pin edge counted once
        pulse_pin(1'b0);
        repeat (2) @(negedge clk);
        rd(3'd1, d); check(d == 8'h0F, "R7 pin edge", d, 8'h0F);
        for (int j = 0; j < 16; j++) pulse_pin(1'b0);
        repeat (2) @(negedge clk);
        rd(3'd1, d); check(d == 8'h20, "R4 reload new value", d, 8'h20);
        check(t1_irq == 1'b1, "R5 flag A set", t1_irq, 1);

        // R10 stopped timer ignores count pulses
        wr(3'd0, {1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 2'b00});
        pulse_pin(1'b0);
        pulse_pin(1'b0);
        rd(3'd1, d); check(d == 8'h20, "R10 stopped hold", d, 8'h20);

        // R6 test-and-clear
        skip_rd(3'd5, d); check(d == 8'd0, "R6 skip B reads 0", d, 0);
        check(t1_irq == 1'b1, "R6 A unaffected", t1_irq, 1);
        skip_rd(3'd4, d); check(d == 8'd1, "R6 skip A reads 1", d, 1);
        check(t1_irq == 1'b0, "R6 A cleared", t1_irq, 0);

        // R5 write-one clear
        wr(3'd2, 8'd3);
        wr(3'd0, {1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 2'b10});
        repeat (6) @(negedge clk);
        wr(3'd0, 8'd0);
        check(t2_irq == 1'b1, "R5 flag B set", t2_irq, 1);
        wr(3'd3, 8'h01);
        check(t2_irq == 1'b1, "R5 other clear bit", t2_irq, 1);
        wr(3'd3, 8'h02);
        check(t2_irq == 1'b0, "R5 clear B", t2_irq, 0);

        // R8 counter-pin source
        wr(3'd2, 8'd1);
        wr(3'd0, {1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'b10});
        k = int'(cnt_out);
        pulse_pin(1'b1);
        check(t2_irq == 1'b0, "R8 pin one edge", t2_irq, 0);
        pulse_pin(1'b1);
        repeat (2) @(negedge clk);
        check(t2_irq == 1'b1, "R8 pin underflow", t2_irq, 1);
        check(int'(cnt_out) != k, "R9 toggle on B", cnt_out, 1 - k);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule